// File: doc/BRIEF.md
# Locked System Control Register Bank

This block is a small memory-mapped bank of system control and status words sitting on a plain register-bus slave port: an address, an access strobe with a write enable, write data in, and read data out. It is clocked by the system bus clock. It carries a fixed identification word, a clock-synthesizer divisor with staged application, a user-LED control word, a write-protection key, a free-running bus-cycle counter and two 32-bit software flag words. The bus is a control path and not a data stream, so it has no valid/ready handshake: every access completes in the cycle it is presented. Reads are combinational from the current register state, and writes take effect at the next rising clock edge.

The block has two reset inputs. Power-on reset clears everything, including the divisor and the persistent flag word. Soft reset clears the key, LEDs, counter and volatile flags. It leaves the staged divisor and the persistent flags as they are, and it moves the staged divisor onto the clock-divisor output. The divisor can only be written after the 16-bit key 0xA05F has been written into the key word. A divisor write does not reach the clock output at once. It is marked pending until a soft reset applies it, unless the write also carries the force bit.

Top module: `sysctl_regbank`

## Requirements
- R1: After power-on reset the following hold. Offset 0x00 reads the ID_WORD parameter. The key word at 0x14 reads 0x0001_0000, which is locked with a zero key. The counter at 0x18 reads 0. Both flag words read 0 and the LED outputs are 0. The staged and applied divisors both hold the default: bits 18:16 = 3'b111, bits 15:9 = 63, bits 8:0 = 255 (value 0x77EFF).
- R2: A write to offset 0x14 stores wdata[15:0], which reads back in bits 15:0. Bit 16 reads 0 when the stored value is 0xA05F and 1 for any other value. Bits 31:17 read 0.
- R3: While locked, a write to the divisor word at 0x08 is ignored: its readback and the clock-divisor output stay unchanged, and the access completes normally.
- R4: While unlocked, a write to 0x08 with bit 26 = 0 stores wdata[18:0] as the staged divisor. Bit 27 (pending) then reads 1, and the clock-divisor output keeps its previous value.
- R5: While unlocked, a write to 0x08 with bit 26 = 1 stores wdata[18:0] and drives it onto the clock-divisor output at the same clock edge. Pending reads 0 afterwards.
- R6: Offset 0x08 reads {4'b0, pending, 8'b0, staged[18:0]}, so the force bit always reads 0. A soft reset copies the staged divisor onto the output and clears pending, and the staged value is kept.
- R7: The 32-bit counter at 0x18 reads 0 while the soft domain is in reset and increases by exactly one on every clock edge after that. Writes to it have no effect.
- R8: The volatile flag word reads at 0x30. A write to 0x30 sets each bit that is 1 in wdata, and a write to 0x34 clears each bit that is 1 in wdata. Zero bits leave flags unchanged.
- R9: The persistent flag word reads at 0x38 and uses the same semantics, with set at 0x38 and clear at 0x3C. It keeps its value through a soft reset and only power-on reset clears it. The volatile word is cleared by a soft reset.
- R10: A write to 0x0C stores wdata[31:28], which drives the four LED outputs. 0x0C reads {led, 28'b0}, and the LED word is not protected by the key.
- R11: Any offset not listed here, including 0x04 and 0x34, reads 0. Writes to unlisted offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| srst_n | input | 1 | Soft reset, active low |
| bus_en | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | Write enable, qualified by bus_en |
| bus_addr | input | ADDR_W (8) | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| led_o | output | 4 | User LED drive |
| clkdiv_o | output | 19 | Applied synthesizer divisor {od, rdw, vdw} |

## Verification
The divisor path is exercised with writes in three conditions: while locked, while unlocked without force, and while unlocked with force. Each of these separates the three possible results: nothing changes, only the staged value and pending bit move, or the output moves as well. Key writes alternate between the exact key, near-miss values and random values, so both lock transitions and the bit-for-bit key match are checked. Random set and clear masks on both flag words, with soft resets placed between them, show apart the two reset domains and the no-change behaviour of zero bits. Writes to unmapped offsets followed by full readback show that no register is touched.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned KEY_W   = 16;
  localparam int unsigned DIV_W   = 19;
  localparam int unsigned LED_W   = 4;

  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA05F;

  localparam int unsigned OFF_ID     = 'h00;
  localparam int unsigned OFF_DIV    = 'h08;
  localparam int unsigned OFF_LED    = 'h0C;
  localparam int unsigned OFF_KEY    = 'h14;
  localparam int unsigned OFF_CNT    = 'h18;
  localparam int unsigned OFF_VF_SET = 'h30;
  localparam int unsigned OFF_VF_CLR = 'h34;
  localparam int unsigned OFF_PF_SET = 'h38;
  localparam int unsigned OFF_PF_CLR = 'h3C;

  localparam int unsigned FORCE_BIT   = 26;
  localparam int unsigned PENDING_BIT = 27;
  localparam int unsigned LOCKED_BIT  = 16;

  typedef struct packed {
    logic [2:0] od;
    logic [6:0] rdw;
    logic [8:0] vdw;
  } div_t;

  localparam div_t DIV_DEFAULT = '{od: 3'b111, rdw: 7'd63, vdw: 9'd255};
endpackage

// File: rtl/sysctl_lock.sv
module sysctl_lock
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wdata,
  output logic [KEY_W-1:0] key_q,
  output logic             locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else if (wr_en) key_q <= wdata;
  end

  assign locked = (key_q != UNLOCK_KEY);

  assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata == UNLOCK_KEY) |=> !locked);
  assert_other_relocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata != UNLOCK_KEY) |=> locked);
endmodule

// File: rtl/sysctl_divisor.sv
module sysctl_divisor
  import sysctl_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic srst_n,
  input  logic wr_en,
  input  logic locked,
  input  div_t wdata,
  input  logic force_apply,
  output div_t staged_o,
  output div_t applied_o,
  output logic pending_o
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      staged_o  <= DIV_DEFAULT;
      applied_o <= DIV_DEFAULT;
      pending_o <= 1'b0;
    end else if (!srst_n) begin
      applied_o <= staged_o;
      pending_o <= 1'b0;
    end else if (wr_en && !locked) begin
      staged_o <= wdata;
      if (force_apply) begin
        applied_o <= wdata;
        pending_o <= 1'b0;
      end else begin
        pending_o <= 1'b1;
      end
    end
  end

  assert_locked_ignored_R3: assert property (@(posedge clk) disable iff (!por_n)
    (srst_n && wr_en && locked) |=> ($stable(staged_o) && $stable(applied_o)));
  assert_staged_pending_R4: assert property (@(posedge clk) disable iff (!por_n)
    (srst_n && wr_en && !locked && !force_apply) |=> (pending_o && $stable(applied_o)));
  assert_force_applies_R5: assert property (@(posedge clk) disable iff (!por_n)
    (srst_n && wr_en && !locked && force_apply) |=> (applied_o == $past(wdata) && !pending_o));
  assert_soft_reset_applies_R6: assert property (@(posedge clk) disable iff (!por_n)
    !srst_n |=> (applied_o == $past(staged_o) && !pending_o));
endmodule

// File: rtl/sysctl_flags.sv
module sysctl_flags #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] flags_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else if (set_we) flags_o <= flags_o | wdata;
    else if (clr_we) flags_o <= flags_o & ~wdata;
  end

  assert_set_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((flags_o & $past(wdata)) == $past(wdata)));
  assert_clear_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((flags_o & $past(wdata)) == '0));
  assert_zero_bits_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we || clr_we) |=> ((flags_o & ~$past(wdata)) == ($past(flags_o) & ~$past(wdata))));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [31:0] ID_WORD = 32'h4103_0010
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              srst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [3:0]        led_o,
  output logic [18:0]       clkdiv_o
);
  localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(OFF_ID);
  localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(OFF_DIV);
  localparam logic [ADDR_W-1:0] A_LED   = ADDR_W'(OFF_LED);
  localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(OFF_KEY);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFF_CNT);
  localparam logic [ADDR_W-1:0] A_VFSET = ADDR_W'(OFF_VF_SET);
  localparam logic [ADDR_W-1:0] A_VFCLR = ADDR_W'(OFF_VF_CLR);
  localparam logic [ADDR_W-1:0] A_PFSET = ADDR_W'(OFF_PF_SET);
  localparam logic [ADDR_W-1:0] A_PFCLR = ADDR_W'(OFF_PF_CLR);
  localparam int unsigned LED_LSB = DATA_W - LED_W;

  logic soft_rst_n;
  assign soft_rst_n = por_n & srst_n;

  logic wr;
  assign wr = bus_en & bus_we;

  logic [KEY_W-1:0]  key_q;
  logic              locked;
  div_t              div_staged, div_applied;
  logic              div_pending;
  logic [DATA_W-1:0] vflags, pflags;
  logic [LED_W-1:0]  led_q;
  logic [DATA_W-1:0] cnt_q;

  sysctl_lock u_lock (
    .clk    (clk),
    .rst_n  (soft_rst_n),
    .wr_en  (wr && bus_addr == A_KEY),
    .wdata  (bus_wdata[KEY_W-1:0]),
    .key_q  (key_q),
    .locked (locked)
  );

  sysctl_divisor u_div (
    .clk         (clk),
    .por_n       (por_n),
    .srst_n      (srst_n),
    .wr_en       (wr && bus_addr == A_DIV),
    .locked      (locked),
    .wdata       (div_t'(bus_wdata[DIV_W-1:0])),
    .force_apply (bus_wdata[FORCE_BIT]),
    .staged_o    (div_staged),
    .applied_o   (div_applied),
    .pending_o   (div_pending)
  );

  sysctl_flags #(.WIDTH(DATA_W)) u_vflags (
    .clk     (clk),
    .rst_n   (soft_rst_n),
    .set_we  (wr && bus_addr == A_VFSET),
    .clr_we  (wr && bus_addr == A_VFCLR),
    .wdata   (bus_wdata),
    .flags_o (vflags)
  );

  sysctl_flags #(.WIDTH(DATA_W)) u_pflags (
    .clk     (clk),
    .rst_n   (por_n),
    .set_we  (wr && bus_addr == A_PFSET),
    .clr_we  (wr && bus_addr == A_PFCLR),
    .wdata   (bus_wdata),
    .flags_o (pflags)
  );

  always_ff @(posedge clk or negedge soft_rst_n) begin
    if (!soft_rst_n) led_q <= '0;
    else if (wr && bus_addr == A_LED) led_q <= bus_wdata[DATA_W-1:LED_LSB];
  end

  always_ff @(posedge clk or negedge soft_rst_n) begin
    if (!soft_rst_n) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ID:    bus_rdata = ID_WORD;
      A_DIV: begin
        bus_rdata[DIV_W-1:0]   = div_staged;
        bus_rdata[PENDING_BIT] = div_pending;
      end
      A_LED:   bus_rdata[DATA_W-1:LED_LSB] = led_q;
      A_KEY: begin
        bus_rdata[KEY_W-1:0]  = key_q;
        bus_rdata[LOCKED_BIT] = locked;
      end
      A_CNT:   bus_rdata = cnt_q;
      A_VFSET: bus_rdata = vflags;
      A_PFSET: bus_rdata = pflags;
      default: bus_rdata = '0;
    endcase
  end

  assign led_o    = led_q;
  assign clkdiv_o = div_applied;

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!soft_rst_n)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_led_hold_R10: assert property (@(posedge clk) disable iff (!soft_rst_n)
    !(wr && bus_addr == A_LED) |=> $stable(led_o));
  assert_clkdiv_quiet_R3: assert property (@(posedge clk) disable iff (!por_n)
    (srst_n && !(wr && bus_addr == A_DIV)) |=> $stable(clkdiv_o));
endmodule

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb;
  localparam logic [31:0] IDW = 32'h4103_0010;
  localparam logic [15:0] KEY = 16'hA05F;
  localparam logic [18:0] DEF = 19'h77EFF;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, srst_n = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  led_o;
  logic [18:0] clkdiv_o;

  int vectors = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_key;
  logic [18:0] m_stg, m_app;
  logic        m_pend;
  logic [31:0] m_vf, m_pf;
  logic [3:0]  m_led;

  sysctl_regbank #(.ADDR_W(8), .ID_WORD(IDW)) u_dut (
    .clk(clk), .por_n(por_n), .srst_n(srst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .led_o(led_o), .clkdiv_o(clkdiv_o));

  always #10 clk = ~clk;

  function automatic logic [31:0] exp_key();
    return {15'b0, (m_key != KEY), m_key};
  endfunction
  function automatic logic [31:0] exp_div();
    return {4'b0, m_pend, 8'b0, m_stg};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rdchk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    case (a)
      8'h14: m_key = d[15:0];
      8'h08: if (m_key == KEY) begin
        m_stg = d[18:0];
        if (d[26]) begin m_app = d[18:0]; m_pend = 1'b0; end
        else m_pend = 1'b1;
      end
      8'h0C: m_led = d[31:28];
      8'h30: m_vf = m_vf | d;
      8'h34: m_vf = m_vf & ~d;
      8'h38: m_pf = m_pf | d;
      8'h3C: m_pf = m_pf & ~d;
      default: ;
    endcase
  endtask

  task automatic check_all(string req);
    rdchk(req, 8'h14, exp_key());
    rdchk(req, 8'h08, exp_div());
    rdchk(req, 8'h0C, {m_led, 28'b0});
    rdchk(req, 8'h30, m_vf);
    rdchk(req, 8'h38, m_pf);
    chk(req, {13'b0, clkdiv_o}, {13'b0, m_app});
    chk(req, {28'b0, led_o}, {28'b0, m_led});
  endtask

  task automatic soft_reset();
    srst_n = 1'b0;
    #1 rdchk("R7", 8'h18, 32'h0);
    @(negedge clk);
    srst_n = 1'b1;
    m_key = '0; m_led = '0; m_vf = '0; m_app = m_stg; m_pend = 1'b0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] c1, c2, r;
    void'($urandom(32'h5eed_1234));
    m_key = '0; m_stg = DEF; m_app = DEF; m_pend = 1'b0;
    m_vf = '0; m_pf = '0; m_led = '0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdchk("R1", 8'h00, IDW);
    rdchk("R1", 8'h14, 32'h0001_0000);
    rdchk("R1", 8'h08, {13'b0, DEF});
    chk("R1", {13'b0, clkdiv_o}, {13'b0, DEF});
    check_all("R1");

    // R7 counter steps by one per clock
    rd(8'h18, c1);
    repeat (7) @(negedge clk);
    rd(8'h18, c2);
    chk("R7", c2 - c1, 32'd7);
    wr(8'h18, 32'hFFFF_0000);
    rd(8'h18, r);
    chk("R7", r - c2, 32'd1);

    // R3 locked write ignored
    wr(8'h08, 32'h0400_1234);
    check_all("R3");

    // R2 near-miss keys keep lock, exact key unlocks, other relocks
    wr(8'h14, 32'hFFFF_A05E); rdchk("R2", 8'h14, exp_key());
    wr(8'h14, 32'h0000_205F); rdchk("R2", 8'h14, exp_key());
    wr(8'h14, 32'h1234_A05F); rdchk("R2", 8'h14, 32'h0000_A05F);

    // R4 staged write, pending, output unchanged
    wr(8'h08, 32'h0001_2345);
    check_all("R4");
    rdchk("R4", 8'h08, 32'h0801_2345);
    // R5 forced write
    wr(8'h08, 32'h0402_0A0B);
    check_all("R5");
    chk("R5", {13'b0, clkdiv_o}, 32'h0002_0A0B);
    // R6 staged write then soft reset applies it
    wr(8'h08, 32'h0005_5555);
    chk("R6", {13'b0, clkdiv_o}, 32'h0002_0A0B);
    wr(8'h30, 32'h0000_00FF);
    wr(8'h38, 32'hF000_000F);
    wr(8'h0C, 32'hA000_0000);
    soft_reset();
    chk("R6", {13'b0, clkdiv_o}, 32'h0005_5555);
    rdchk("R6", 8'h08, 32'h0005_5555);
    // R9 persistent flags survive, volatile cleared
    rdchk("R9", 8'h38, 32'hF000_000F);
    rdchk("R9", 8'h30, 32'h0);
    check_all("R9");

    // R10 LED unprotected while locked
    wr(8'h0C, 32'h5FFF_FFFF);
    rdchk("R10", 8'h0C, 32'h5000_0000);
    chk("R10", {28'b0, led_o}, 32'h5);

    // R11 unmapped offsets
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rdchk("R11", 8'h04, 32'h0);
    rdchk("R11", 8'h34, 32'h0);
    rdchk("R11", 8'h3C, 32'h0);
    rdchk("R11", 8'h40, 32'h0);
    check_all("R11");

    // R8 random set/clear, random lock and divisor traffic
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom_range(0, 9));
      d = $urandom;
      case (op)
        0: wr(8'h30, d);
        1: wr(8'h34, d);
        2: wr(8'h38, d);
        3: wr(8'h3C, d);
        4: wr(8'h14, ($urandom_range(0, 2) != 0) ? {d[31:16], KEY} : d);
        5, 6: wr(8'h08, d);
        7: wr(8'h0C, d);
        8: if ($urandom_range(0, 5) == 0) soft_reset(); else wr(8'h30, 32'h0);
        default: wr({d[7:6] | 2'b01, d[5:0]}, d);
      endcase
      check_all((op < 2) ? "R8" : (op < 4) ? "R9" : (op < 7) ? "R4" : "R11");
    end

    // R9 power-on reset clears persistent flags
    wr(8'h38, 32'hDEAD_BEEF);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    m_key = '0; m_stg = DEF; m_app = DEF; m_pend = 1'b0;
    m_vf = '0; m_pf = '0; m_led = '0;
    rdchk("R9", 8'h38, 32'h0);
    check_all("R1");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule